// File: doc/BRIEF.md
# Memory Error Capture Register

This block sits beside the error-correcting path of a memory controller and keeps a record of the first correctable (single-bit) and the first uncorrectable (multi-bit) memory error for software to inspect. The correction logic reports each error as a one-cycle pulse. Each pulse comes with the 4 KB page number of the failing access and the index of the memory row that was hit. Software reads and clears the record through a small register bus with three registers, selected by a 2-bit index: the error address pointer (index 0), the error status (index 1) and the error command (index 2).

Every recorded item is frozen once it is captured. A later error of the same class leaves it alone until software clears the matching flag by writing 1 to it. The address pointer holds one page number and a flag for each class. The status register holds a flag for each class and, separately for each class, the row of the first failing access. The command register enables, separately for each class, a system-error output that stays high while that class's status flag is set.

Each capture slot is a two-state machine. In `CAP_OPEN` the slot is empty. The transition `capture` (error pulse while open) moves it to `CAP_HELD`. In `CAP_HELD` the transition `release` (write of 1 to the flag) returns it to `CAP_OPEN`. The transition `recapture` (a release and a new pulse in the same cycle) keeps it in `CAP_HELD` and loads the new values. All other cases leave the slot where it is.

Top module: `mem_err_capture`

## Requirements
- R1: After reset all flags, rows, the page field and the command register read as 0, and `serr_o` is low.
- R2: A single-bit pulse while address flag bit 0 is clear sets bit 0 of the address pointer and loads bits 31:12 with `sbe_page_i`. Bits 11:2 always read 0.
- R3: A multi-bit pulse while address flag bit 1 is clear sets bit 1 and loads bits 31:12 with `mbe_page_i`. When both classes are accepted in the same cycle, bits 31:12 take the multi-bit page.
- R4: While an address flag is set, further pulses of that class change neither the flag nor the page field.
- R5: Writing 1 to address pointer bit 0 or 1, or to status bit 0 or 4, clears that flag. Writing 0 leaves it unchanged. Writes never alter the page field or the row fields.
- R6: In the status register, a single-bit pulse with bit 0 clear sets bit 0 and stores `sbe_row_i` in bits 3:1. A multi-bit pulse with bit 4 clear sets bit 4 and stores `mbe_row_i` in bits 7:5. Rows stay frozen while their flag is set. Status bits 15:8 read 0.
- R7: Command bits 1:0 are read/write; bit 1 enables the multi-bit class and bit 0 the single-bit class. `serr_o` is high exactly while some status flag is set with its enable set.
- R8: A pulse arriving in the same cycle as a write that clears its flag is captured, and the flag stays set.
- R9: Index 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_i | input | 1 | Single-bit error pulse |
| sbe_page_i | input | 20 | Page number (address bits 31:12) of the single-bit error |
| sbe_row_i | input | 3 | Row index of the single-bit error |
| mbe_i | input | 1 | Multi-bit error pulse |
| mbe_page_i | input | 20 | Page number of the multi-bit error |
| mbe_row_i | input | 3 | Row index of the multi-bit error |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Access is a write |
| bus_idx_i | input | 2 | Register index: 0 address pointer, 1 status, 2 command |
| bus_wdata_i | input | 8 | Write data (low byte) |
| bus_rdata_o | output | 32 | Read data of the indexed register |
| serr_o | output | 1 | System-error output |

## Verification
The bench goes after several capture cases:
- An error that arrives in the same cycle as the clear of its flag. A design that checks only the old flag would drop this error.
- Both classes arriving together. Here the page must come from the multi-bit error; an inverted priority would log the single-bit page.
- Write data holding zeros in the flag positions. A design that writes instead of clearing on 1 would wipe flags or overwrite the page.
- Errors arriving while a slot is held. A slot that does not freeze would show the later row or page.

The command enables are also toggled while flags are set, which would expose a system-error output that ignores its enable.

// File: rtl/mecr_pkg.sv
package mecr_pkg;
    typedef enum logic {
        CAP_OPEN = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    typedef enum logic [1:0] {
        IDX_EAP  = 2'd0,
        IDX_STS  = 2'd1,
        IDX_CMD  = 2'd2,
        IDX_NONE = 2'd3
    } reg_idx_e;

    localparam int CLS_SBE = 0;
    localparam int CLS_MBE = 1;
    localparam int NUM_CLS = 2;
endpackage

// File: rtl/mecr_row_slot.sv
module mecr_row_slot
    import mecr_pkg::*;
#(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             clr_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             held_o,
    output logic [ROW_W-1:0] row_o
);
    cap_state_e        state_q, state_d;
    logic [ROW_W-1:0]  row_q;
    logic              load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_OPEN: begin
                if (err_i) begin
                    state_d = CAP_HELD;
                    load    = 1'b1;
                end
            end
            CAP_HELD: begin
                if (clr_i && err_i) begin
                    load = 1'b1;
                end else if (clr_i) begin
                    state_d = CAP_OPEN;
                end
            end
            default: state_d = CAP_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    row_q <= '0;
        else if (load) row_q <= row_i;
    end

    assign held_o = (state_q == CAP_HELD);
    assign row_o  = row_q;

    // R6: a held row is frozen unless its flag is cleared in that cycle
    a_r6_row_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !clr_i) |=> ($stable(row_o) && held_o));
    // R5: the flag only drops after a clear request
    a_r5_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held_o) |-> $past(clr_i));
endmodule

// File: rtl/mecr_addr_capture.sv
module mecr_addr_capture
    import mecr_pkg::*;
#(
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbe_i,
    input  logic [PAGE_W-1:0] sbe_page_i,
    input  logic              mbe_i,
    input  logic [PAGE_W-1:0] mbe_page_i,
    input  logic              clr_sbe_i,
    input  logic              clr_mbe_i,
    output logic              sbe_flag_o,
    output logic              mbe_flag_o,
    output logic [PAGE_W-1:0] page_o
);
    cap_state_e        s_state_q, s_state_d, m_state_q, m_state_d;
    logic [PAGE_W-1:0] page_q;
    logic              s_take, m_take;

    always_comb begin
        s_state_d = s_state_q;
        s_take    = 1'b0;
        unique case (s_state_q)
            CAP_OPEN: if (sbe_i) begin s_state_d = CAP_HELD; s_take = 1'b1; end
            CAP_HELD: begin
                if (clr_sbe_i && sbe_i) s_take = 1'b1;
                else if (clr_sbe_i)     s_state_d = CAP_OPEN;
            end
            default: s_state_d = CAP_OPEN;
        endcase
    end

    always_comb begin
        m_state_d = m_state_q;
        m_take    = 1'b0;
        unique case (m_state_q)
            CAP_OPEN: if (mbe_i) begin m_state_d = CAP_HELD; m_take = 1'b1; end
            CAP_HELD: begin
                if (clr_mbe_i && mbe_i) m_take = 1'b1;
                else if (clr_mbe_i)     m_state_d = CAP_OPEN;
            end
            default: m_state_d = CAP_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_state_q <= CAP_OPEN;
            m_state_q <= CAP_OPEN;
        end else begin
            s_state_q <= s_state_d;
            m_state_q <= m_state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      page_q <= '0;
        else if (m_take) page_q <= mbe_page_i;
        else if (s_take) page_q <= sbe_page_i;
    end

    assign sbe_flag_o = (s_state_q == CAP_HELD);
    assign mbe_flag_o = (m_state_q == CAP_HELD);
    assign page_o     = page_q;

    // R3: an accepted multi-bit error always supplies the page
    a_r3_mbe_page_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_i && (!mbe_flag_o || clr_mbe_i)) |=> (mbe_flag_o && page_o == $past(mbe_page_i)));
    // R2: a lone accepted single-bit error loads its page
    a_r2_sbe_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_i && !mbe_i && (!sbe_flag_o || clr_sbe_i)) |=> (sbe_flag_o && page_o == $past(sbe_page_i)));
    // R4: with both flags held and no clears, the page is frozen
    a_r4_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_flag_o && mbe_flag_o && !clr_sbe_i && !clr_mbe_i) |=> $stable(page_o));
    // R5: address flags fall only after a clear request
    a_r5_sflag_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sbe_flag_o) |-> $past(clr_sbe_i));
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
    import mecr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 12,
    parameter int ROW_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sbe_i,
    input  logic [ADDR_W-PAGE_LSB-1:0] sbe_page_i,
    input  logic [ROW_W-1:0]         sbe_row_i,
    input  logic                     mbe_i,
    input  logic [ADDR_W-PAGE_LSB-1:0] mbe_page_i,
    input  logic [ROW_W-1:0]         mbe_row_i,
    input  logic                     bus_sel_i,
    input  logic                     bus_wr_i,
    input  logic [1:0]               bus_idx_i,
    input  logic [7:0]               bus_wdata_i,
    output logic [ADDR_W-1:0]        bus_rdata_o,
    output logic                     serr_o
);
    localparam int PAGE_W  = ADDR_W - PAGE_LSB;
    localparam int FIELD_W = ROW_W + 1;
    localparam int STS_W   = 16;
    localparam int STS_USE = NUM_CLS * FIELD_W;

    logic wr_eap, wr_sts, wr_cmd;
    logic [NUM_CLS-1:0] ap_flag, sts_flag, sts_clr, err_v;
    logic [ROW_W-1:0]   row_in  [NUM_CLS];
    logic [ROW_W-1:0]   row_out [NUM_CLS];
    logic [PAGE_W-1:0]  page;
    logic [NUM_CLS-1:0] cmd_q;
    logic [STS_USE-1:0] sts_word;

    assign wr_eap = bus_sel_i && bus_wr_i && (bus_idx_i == IDX_EAP);
    assign wr_sts = bus_sel_i && bus_wr_i && (bus_idx_i == IDX_STS);
    assign wr_cmd = bus_sel_i && bus_wr_i && (bus_idx_i == IDX_CMD);

    assign err_v[CLS_SBE]  = sbe_i;
    assign err_v[CLS_MBE]  = mbe_i;
    assign row_in[CLS_SBE] = sbe_row_i;
    assign row_in[CLS_MBE] = mbe_row_i;

    mecr_addr_capture #(.PAGE_W(PAGE_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sbe_i      (sbe_i),
        .sbe_page_i (sbe_page_i),
        .mbe_i      (mbe_i),
        .mbe_page_i (mbe_page_i),
        .clr_sbe_i  (wr_eap && bus_wdata_i[CLS_SBE]),
        .clr_mbe_i  (wr_eap && bus_wdata_i[CLS_MBE]),
        .sbe_flag_o (ap_flag[CLS_SBE]),
        .mbe_flag_o (ap_flag[CLS_MBE]),
        .page_o     (page)
    );

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign sts_clr[c] = wr_sts && bus_wdata_i[c*FIELD_W];
        mecr_row_slot #(.ROW_W(ROW_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .err_i  (err_v[c]),
            .clr_i  (sts_clr[c]),
            .row_i  (row_in[c]),
            .held_o (sts_flag[c]),
            .row_o  (row_out[c])
        );
        assign sts_word[c*FIELD_W +: FIELD_W] = {row_out[c], sts_flag[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmd_q <= '0;
        else if (wr_cmd) cmd_q <= bus_wdata_i[NUM_CLS-1:0];
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_idx_i)
            IDX_EAP:  bus_rdata_o = {page, {(PAGE_LSB-NUM_CLS){1'b0}}, ap_flag};
            IDX_STS:  bus_rdata_o[STS_W-1:0] = {{(STS_W-STS_USE){1'b0}}, sts_word};
            IDX_CMD:  bus_rdata_o[NUM_CLS-1:0] = cmd_q;
            IDX_NONE: bus_rdata_o = '0;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign serr_o = |(sts_flag & cmd_q);

    // R7: the system-error output never rises without some enable set
    a_r7_serr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> (cmd_q != '0));
    // R1: right after reset release nothing is flagged
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (ap_flag == '0 && sts_flag == '0));
endmodule

// File: tb/mem_err_capture_test.sv
`timescale 1ns/1ps
module mem_err_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sbe = 1'b0, mbe = 1'b0;
    logic [19:0] sbe_page = '0, mbe_page = '0;
    logic [2:0]  sbe_row = '0, mbe_row = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  idx = '0;
    logic [7:0]  wdata = '0;
    logic [31:0] rdata;
    logic        serr;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference state
    logic [19:0] m_page;
    logic        m_asf, m_amf, m_sef, m_mef;
    logic [2:0]  m_srow, m_mrow;
    logic [1:0]  m_cmd;

    always #2 clk = ~clk;

    mem_err_capture uut (
        .clk(clk), .rst_n(rst_n),
        .sbe_i(sbe), .sbe_page_i(sbe_page), .sbe_row_i(sbe_row),
        .mbe_i(mbe), .mbe_page_i(mbe_page), .mbe_row_i(mbe_row),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_idx_i(idx), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .serr_o(serr)
    );

    function automatic logic [31:0] exp_eap();
        return {m_page, 10'b0, m_amf, m_asf};
    endfunction
    function automatic logic [31:0] exp_sts();
        return {24'b0, m_mrow, m_mef, m_srow, m_sef};
    endfunction
    function automatic logic exp_serr();
        return (m_sef & m_cmd[0]) | (m_mef & m_cmd[1]);
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        idx = 2'd0; #0.2; cmp({tag, " R2 R3 R4 address pointer"}, rdata, exp_eap());
        idx = 2'd1; #0.2; cmp({tag, " R6 status"}, rdata, exp_sts());
        idx = 2'd2; #0.2; cmp({tag, " R7 command"}, rdata, {30'b0, m_cmd});
        idx = 2'd3; #0.2; cmp({tag, " R9 unmapped index"}, rdata, 32'b0);
        cmp({tag, " R7 serr"}, {31'b0, serr}, {31'b0, exp_serr()});
    endtask

    // one clock: inputs already driven after a falling edge
    task automatic step();
        logic we, cs, cm, acc_s, acc_m;
        @(posedge clk);
        we = sel && wr;
        cs = we && idx == 2'd0 && wdata[0];
        cm = we && idx == 2'd0 && wdata[1];
        acc_s = sbe && (!m_asf || cs);
        acc_m = mbe && (!m_amf || cm);
        if (acc_m)      m_page = mbe_page;
        else if (acc_s) m_page = sbe_page;
        m_asf = acc_s || (m_asf && !cs);
        m_amf = acc_m || (m_amf && !cm);
        cs = we && idx == 2'd1 && wdata[0];
        cm = we && idx == 2'd1 && wdata[4];
        acc_s = sbe && (!m_sef || cs);
        acc_m = mbe && (!m_mef || cm);
        if (acc_s) m_srow = sbe_row;
        if (acc_m) m_mrow = mbe_row;
        m_sef = acc_s || (m_sef && !cs);
        m_mef = acc_m || (m_mef && !cm);
        if (we && idx == 2'd2) m_cmd = wdata[1:0];
        #1;
        sbe = 1'b0; mbe = 1'b0; sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] i, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; idx = i; wdata = d;
        step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_page = '0; m_asf = 0; m_amf = 0; m_sef = 0; m_mef = 0;
        m_srow = '0; m_mrow = '0; m_cmd = '0;
        repeat (3) @(posedge clk);
        #1; check_all("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1; check_all("R1 after release");

        // R2 R6: first single-bit error
        @(negedge clk); sbe = 1; sbe_page = 20'hABCDE; sbe_row = 3'd5;
        step(); check_all("R2 first sbe");
        // R4: second single-bit error is ignored
        @(negedge clk); sbe = 1; sbe_page = 20'h11111; sbe_row = 3'd2;
        step(); check_all("R4 frozen sbe");
        // R5: zero writes and address bits have no effect
        bus_write(2'd0, 8'hFC); check_all("R5 zero write eap");
        bus_write(2'd1, 8'hEE); check_all("R5 zero write sts");
        // R7: enable single-bit system error
        bus_write(2'd2, 8'h01); check_all("R7 enable sbe");
        bus_write(2'd2, 8'h02); check_all("R7 enable mbe only");
        // R3 R8: clear sbe flag while both classes arrive
        @(negedge clk); sel = 1; wr = 1; idx = 2'd0; wdata = 8'h01;
        sbe = 1; sbe_page = 20'h22222; mbe = 1; mbe_page = 20'h33333;
        sbe_row = 3'd1; mbe_row = 3'd6;
        step(); check_all("R3 R8 both with clear");
        // R8 on the status register
        @(negedge clk); sel = 1; wr = 1; idx = 2'd1; wdata = 8'h11;
        sbe = 1; sbe_row = 3'd7; mbe = 1; mbe_row = 3'd3;
        step(); check_all("R8 status clear and set");
        // R9: write to unmapped index
        bus_write(2'd3, 8'hFF); check_all("R9 unmapped write");
        // R5: clear everything
        bus_write(2'd0, 8'h03); bus_write(2'd1, 8'h11); check_all("R5 clear all");

        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            sbe = ($urandom % 4) == 0;
            mbe = ($urandom % 6) == 0;
            sbe_page = 20'($urandom); mbe_page = 20'($urandom);
            sbe_row = 3'($urandom); mbe_row = 3'($urandom);
            if (($urandom % 3) == 0) begin
                sel = 1; wr = ($urandom % 4) != 0;
                idx = 2'($urandom); wdata = 8'($urandom);
            end
            step();
            check_all("random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule